// File: doc/BRIEF.md
# Transmit Timestamp and Time-Sync Event Unit

This block sits beside the precision clock of a network port. When the transmitter starts a frame that asks for a timestamp, the block copies the running clock value (seconds and nanoseconds) into a holding register. It also records time-sync events in a sticky cause register. The causes that the mask register enables are combined into one interrupt line.

Software reads the captured value through a small register interface: the nanoseconds word first, then the seconds word. Reading the seconds word releases the hold, so the next marked frame can be stamped and its event can raise the interrupt again. While a value is held, further start-of-frame strobes leave it untouched. This keeps the first stamp intact until software has collected it.

The capture path is a two-state machine:
- State `TS_ARMED` is the reset state, waiting for a strobe.
- State `TS_HELD` holds a value.
- Transition CAPTURE (`TS_ARMED` to `TS_HELD`) is taken on a start-of-frame strobe.
- Transition RELEASE (`TS_HELD` to `TS_ARMED`) is taken on a read of the seconds word.
- Every other combination leaves the state where it is.

Register selects on `reg_addr`:
- 0: captured nanoseconds.
- 1: captured seconds. A read of this word releases the hold.
- 2: event causes. A read of this word clears them.
- 3: event enables (the mask).

Top module: `tsu_event_unit`

## Requirements
- R1: After reset, the state is `TS_ARMED` and `irq` is low. Reads of all four registers return 0.
- R2: In `TS_ARMED`, a high `tx_sof` at a clock edge takes CAPTURE and stores `ns_in` and `sec_in`. A read of select 0 then returns the nanoseconds, zero-extended. A read of select 1 returns the seconds, zero-extended.
- R3: In `TS_HELD`, strobes on `tx_sof` are ignored and the held value does not change. A read of select 0 does not release the hold.
- R4: A read of select 1 in `TS_HELD` takes RELEASE. The next strobe then captures a fresh value.
- R5: Cause bit 0 sets on a `wrap_pulse`. Cause bit 1 sets on each CAPTURE. Both bits are sticky until a cause read.
- R6: A read of select 2 returns the causes as they stood before that edge and clears them at the same edge. An event at that same edge is still recorded afterwards.
- R7: Cause bits 2 to 6 (target-time and auxiliary events, which have no source here) and all bits above bit 6 always read as 0.
- R8: A write to select 3 stores the mask bits 0, 1 and 3 to 6. Other bits read back as 0, so writing all ones reads back 0x7B. A mask of 0x2 enables only the transmit-timestamp cause.
- R9: `irq` is high exactly while some cause bit and its mask bit are both set. It follows from registers, so it changes after the edge that changes a cause or the mask.
- R10: `reg_rdata` is registered. It shows the selected register after the edge that samples `reg_rd`, and it keeps that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ns_in | input | NS_W | Live nanoseconds of the clock |
| sec_in | input | SEC_W | Live seconds of the clock |
| tx_sof | input | 1 | Start of a frame that needs a timestamp |
| wrap_pulse | input | 1 | One-cycle pulse when the clock wraps |
| reg_addr | input | 2 | Register select |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Summary time-sync interrupt |

## Verification
Every result is due one clock edge after its stimulus:
- A capture, a cause bit and the interrupt change at the edge that samples `tx_sof` or `wrap_pulse`.
- Read data appears after the edge that samples `reg_rd`.
- A mask write changes `irq` from the following edge.

The bench drives each stimulus on the falling edge and samples one time unit after the next rising edge. That is exactly the point where each result is due. Cases that happen at the same edge, such as an event during a cause read or a strobe while a value is held, are placed so that the ordering rule in R6 or R3 decides the expected value.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

    localparam int REG_AW  = 2;
    localparam int CAUSE_W = 7;

    // cause bit positions; software decodes these
    localparam int C_WRAP = 0;
    localparam int C_TXTS = 1;

    // which cause bits have a source in this block
    localparam logic [CAUSE_W-1:0] CAUSE_LIVE = 7'b000_0011;
    // writable mask bits
    localparam logic [CAUSE_W-1:0] MASK_WMASK = 7'b111_1011;

    typedef enum logic [REG_AW-1:0] {
        SEL_TS_NS = 2'd0,
        SEL_TS_SEC = 2'd1,
        SEL_CAUSE = 2'd2,
        SEL_MASK = 2'd3
    } reg_sel_e;

    typedef enum logic {
        TS_ARMED = 1'b0,
        TS_HELD  = 1'b1
    } cap_state_e;

endpackage

// File: rtl/tsu_capture.sv
module tsu_capture
    import tsu_pkg::*;
#(
    parameter int NS_W  = 32,
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             release_req,
    input  logic [NS_W-1:0]  ns_in,
    input  logic [SEC_W-1:0] sec_in,
    output logic             held,
    output logic             capture_pulse,
    output logic [NS_W-1:0]  cap_ns,
    output logic [SEC_W-1:0] cap_sec
);

    cap_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TS_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: CAPTURE and RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_ARMED: if (sof)         state_d = TS_HELD;
            TS_HELD:  if (release_req) state_d = TS_ARMED;
            default:                   state_d = TS_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        held          = 1'b0;
        capture_pulse = 1'b0;
        unique case (state_q)
            TS_ARMED: capture_pulse = sof;
            TS_HELD:  held = 1'b1;
            default:  held = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_ns  <= '0;
            cap_sec <= '0;
        end else if (capture_pulse) begin
            cap_ns  <= ns_in;
            cap_sec <= sec_in;
        end
    end

endmodule

// File: rtl/tsu_cause.sv
module tsu_cause
    import tsu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] events,
    input  logic               clr,
    input  logic               mask_we,
    input  logic [CAUSE_W-1:0] mask_wdata,
    output logic [CAUSE_W-1:0] cause_q,
    output logic [CAUSE_W-1:0] mask_q,
    output logic               irq
);

    for (genvar i = 0; i < CAUSE_W; i++) begin : g_bit
        if (CAUSE_LIVE[i]) begin : g_live
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cause_q[i] <= 1'b0;
                end else begin
                    // a new event beats the clear of the same edge
                    cause_q[i] <= (cause_q[i] & ~clr) | events[i];
                end
            end
        end else begin : g_dead
            logic unused_evt;
            assign unused_evt = events[i];
            assign cause_q[i] = 1'b0;
        end

        if (MASK_WMASK[i]) begin : g_mw
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mask_q[i] <= 1'b0;
                end else if (mask_we) begin
                    mask_q[i] <= mask_wdata[i];
                end
            end
        end else begin : g_mro
            logic unused_mw;
            assign unused_mw = mask_wdata[i];
            assign mask_q[i] = 1'b0;
        end
    end

    assign irq = |(cause_q & mask_q);

endmodule

// File: rtl/tsu_regif.sv
module tsu_regif
    import tsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NS_W   = 32,
    parameter int SEC_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_AW-1:0]  addr,
    input  logic               rd,
    input  logic               wr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               held,
    input  logic [NS_W-1:0]    cap_ns,
    input  logic [SEC_W-1:0]   cap_sec,
    input  logic [CAUSE_W-1:0] cause_q,
    input  logic [CAUSE_W-1:0] mask_q,
    output logic [DATA_W-1:0]  rdata,
    output logic               cause_clr,
    output logic               ts_release,
    output logic               mask_we,
    output logic [CAUSE_W-1:0] mask_wdata
);

    reg_sel_e sel;
    logic [DATA_W-1:0] rd_mux;
    logic unused_wdata_hi;

    assign sel        = reg_sel_e'(addr);
    assign cause_clr  = rd && (sel == SEL_CAUSE);
    assign ts_release = rd && (sel == SEL_TS_SEC) && held;
    assign mask_we    = wr && (sel == SEL_MASK);
    assign mask_wdata = wdata[CAUSE_W-1:0];
    assign unused_wdata_hi = ^wdata[DATA_W-1:CAUSE_W];

    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_TS_NS:  rd_mux[NS_W-1:0]    = cap_ns;
            SEL_TS_SEC: rd_mux[SEC_W-1:0]   = cap_sec;
            SEL_CAUSE:  rd_mux[CAUSE_W-1:0] = cause_q;
            SEL_MASK:   rd_mux[CAUSE_W-1:0] = mask_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/tsu_event_unit.sv
module tsu_event_unit
    import tsu_pkg::*;
#(
    parameter int NS_W   = 32,
    parameter int SEC_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NS_W-1:0]   ns_in,
    input  logic [SEC_W-1:0]  sec_in,
    input  logic              tx_sof,
    input  logic              wrap_pulse,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    logic               cap_held;
    logic               cap_pulse;
    logic [NS_W-1:0]    cap_ns;
    logic [SEC_W-1:0]   cap_sec;
    logic [CAUSE_W-1:0] cause_q;
    logic [CAUSE_W-1:0] mask_q;
    logic [CAUSE_W-1:0] events;
    logic               cause_clr;
    logic               ts_release;
    logic               mask_we;
    logic [CAUSE_W-1:0] mask_wdata;

    always_comb begin
        events         = '0;
        events[C_WRAP] = wrap_pulse;
        events[C_TXTS] = cap_pulse;
    end

    tsu_capture #(.NS_W(NS_W), .SEC_W(SEC_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .sof(tx_sof), .release_req(ts_release),
        .ns_in(ns_in), .sec_in(sec_in), .held(cap_held),
        .capture_pulse(cap_pulse), .cap_ns(cap_ns), .cap_sec(cap_sec)
    );

    tsu_cause u_cause (
        .clk(clk), .rst_n(rst_n), .events(events), .clr(cause_clr),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .cause_q(cause_q), .mask_q(mask_q), .irq(irq)
    );

    tsu_regif #(.DATA_W(DATA_W), .NS_W(NS_W), .SEC_W(SEC_W)) u_rif (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .rd(reg_rd), .wr(reg_wr),
        .wdata(reg_wdata), .held(cap_held), .cap_ns(cap_ns), .cap_sec(cap_sec),
        .cause_q(cause_q), .mask_q(mask_q), .rdata(reg_rdata),
        .cause_clr(cause_clr), .ts_release(ts_release),
        .mask_we(mask_we), .mask_wdata(mask_wdata)
    );

endmodule

// File: rtl/tsu_event_unit_chk.sv
module tsu_event_unit_chk #(
    parameter int NS_W   = 32,
    parameter int SEC_W  = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NS_W-1:0]   ns_in,
    input logic [SEC_W-1:0]  sec_in,
    input logic              tx_sof,
    input logic              wrap_pulse,
    input logic [1:0]        reg_addr,
    input logic              reg_rd,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              held,
    input logic [NS_W-1:0]   cap_ns,
    input logic [SEC_W-1:0]  cap_sec,
    input logic [6:0]        cause_q
);

    AST_CAPTURE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && tx_sof) |=> (held && cap_ns == $past(ns_in) && cap_sec == $past(sec_in))); // R2

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !(reg_rd && reg_addr == 2'd1)) |=> (held && $stable(cap_ns) && $stable(cap_sec))); // R3

    AST_RELEASE_ON_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        (held && reg_rd && reg_addr == 2'd1) |=> !held); // R4

    AST_TX_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> cause_q[1]); // R5

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd2 && !wrap_pulse && !(tx_sof && !held)) |=> (cause_q == 7'd0)); // R6

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd2) |=> (reg_rdata[DATA_W-1:2] == '0)); // R7

endmodule

bind tsu_event_unit tsu_event_unit_chk #(.NS_W(NS_W), .SEC_W(SEC_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ns_in(ns_in), .sec_in(sec_in), .tx_sof(tx_sof),
    .wrap_pulse(wrap_pulse), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .held(cap_held), .cap_ns(cap_ns), .cap_sec(cap_sec),
    .cause_q(cause_q)
);

// File: tb/sim_tsu_event_unit.sv
`timescale 1ns/1ps
module sim_tsu_event_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ns_in = '0;
    logic [31:0] sec_in = '0;
    logic        tx_sof = 1'b0;
    logic        wrap_pulse = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsu_event_unit u0 (
        .clk(clk), .rst_n(rst_n), .ns_in(ns_in), .sec_in(sec_in),
        .tx_sof(tx_sof), .wrap_pulse(wrap_pulse), .reg_addr(reg_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // drive at the falling edge, return one unit after the next rising edge
    task automatic step(input logic rd, input logic wr, input logic [1:0] a,
                        input logic [31:0] wd, input logic sof, input logic wrp);
        @(negedge clk);
        reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        tx_sof = sof; wrap_pulse = wrp;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 2'd0, 32'd0, 1'b0, 1'b0);
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
        step(1'b1, 1'b0, a, 32'd0, 1'b0, 1'b0);
        v = reg_rdata;
        idle();
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        step(1'b0, 1'b1, a, d, 1'b0, 1'b0);
        idle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] held_v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;

        // R1 reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            rd_reg(a[1:0], v);
            check("R1 reg", v, 32'd0);
        end

        // R8 mask write readback
        wr_reg(2'd3, 32'hFFFF_FFFF);
        rd_reg(2'd3, v);
        check("R8 mask all ones", v, 32'h7B);
        wr_reg(2'd3, 32'h2);
        rd_reg(2'd3, v);
        check("R8 mask tx only", v, 32'h2);

        // R2 capture, R9 irq
        ns_in = 32'd123456789; sec_in = 32'h0000_5EED;
        step(1'b0, 1'b0, 2'd0, 32'd0, 1'b1, 1'b0);
        check("R9 irq after capture", {31'd0, irq}, 32'd1);
        idle();

        // R3 later strobe ignored
        ns_in = 32'd999; sec_in = 32'd77;
        step(1'b0, 1'b0, 2'd0, 32'd0, 1'b1, 1'b0);
        idle();
        rd_reg(2'd0, v);
        check("R2 ns word", v, 32'd123456789);
        rd_reg(2'd0, v);
        check("R3 ns read does not release", v, 32'd123456789);

        // R10 rdata holds
        held_v = reg_rdata;
        repeat (3) idle();
        check("R10 rdata holds", reg_rdata, held_v);

        // R5/R6 cause read then cleared
        rd_reg(2'd2, v);
        check("R5 tx cause", v, 32'h2);
        check("R9 irq cleared", {31'd0, irq}, 32'd0);
        rd_reg(2'd2, v);
        check("R6 cause cleared", v, 32'd0);

        // R2 seconds word, R4 release
        rd_reg(2'd1, v);
        check("R2 sec word", v, 32'h5EED);
        ns_in = 32'd4242; sec_in = 32'd88;
        step(1'b0, 1'b0, 2'd0, 32'd0, 1'b1, 1'b0);
        idle();
        rd_reg(2'd0, v);
        check("R4 fresh ns after release", v, 32'd4242);
        rd_reg(2'd1, v);
        check("R4 fresh sec after release", v, 32'd88);
        rd_reg(2'd2, v);
        check("R5 tx cause again", v, 32'h2);

        // R6 event at the same edge as a cause read
        step(1'b1, 1'b0, 2'd2, 32'd0, 1'b0, 1'b1);
        check("R6 read shows old causes", reg_rdata, 32'd0);
        check("R9 wrap masked", {31'd0, irq}, 32'd0);
        idle();
        rd_reg(2'd2, v);
        check("R6 event kept over clear", v, 32'h1);

        // sweep of mask and event combinations
        for (int m = 0; m < 4; m++) begin
            wr_reg(2'd3, m);
            for (int e = 0; e < 4; e++) begin
                ns_in = 32'd1000 * m + e; sec_in = 32'd50 + e;
                step(1'b0, 1'b0, 2'd0, 32'd0, e[1], e[0]);
                check("R9 sweep irq", {31'd0, irq}, {31'd0, |(e[1:0] & m[1:0])});
                idle();
                rd_reg(2'd2, v);
                check("R5 R7 sweep cause", v, e);
                if (e[1]) begin
                    rd_reg(2'd0, v);
                    check("R2 sweep ns", v, 32'd1000 * m + e);
                end
                rd_reg(2'd1, v);
            end
        end

        finish_run();
    end

endmodule